// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a slave on a two-wire serial management bus. It owns a bank of eight 8-bit configuration registers that drive a flat parallel bus into the rest of the chip. The registers come up with fixed defaults when reset is asserted, so software does not need the bus for normal operation. The bus is used only when the defaults need changing or reading back.

Both bus lines come in as open-drain inputs. They pass through a synchroniser clocked by the system clock, and the start, stop and clock-edge events are decoded from the synchronised samples. The slave pulls SDA low through a single output enable, which it uses to acknowledge and to shift read data.

The first byte after the slave address is a command. When the command's top bit is set, a single register is read or written at the offset held in the low seven bits. When the top bit is clear, a counted block transfer runs from register zero upward. On a block write the master sends a byte count before the data. On a block read the slave sends its own byte count first and then the register contents.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69, which appears on the wire as 0xD2 for a write or 0xD3 for a read. Any other address gets no acknowledge, and the slave ignores every later byte until the next start condition, so it changes no register.
- R2: A command with bit 7 set (for example 0x83) makes the next data byte a write to the register at offset cmd[6:0]. Further data bytes in the same transfer are acknowledged but discarded. A write to an offset of 8 or more is acknowledged and discarded.
- R3: A byte read is a write of the address and the command, then a repeated start and the address with R=1. It returns the register at cmd[6:0], most significant bit first. An offset of 8 or more returns 0x00.
- R4: A command of 0x00 starts a block write. The next byte is a count, and the data bytes after it land in registers 0, 1, 2 and upward. The slave acknowledges every byte. Bytes past register 7 are acknowledged and discarded.
- R5: A block read (command 0x00, then a repeated start and a read) returns the count 0x08, then registers 0 to 7 in order. Any bytes requested after that read as 0x00.
- R6: Each data byte takes effect at the falling SCL edge that ends its eighth bit. A stop or start condition in the middle of a byte abandons that byte and leaves the bytes already written in place.
- R7: After the master NACKs a read byte, the slave releases SDA and keeps it released until the next start or stop condition.
- R8: Reset loads register i with (i+1)*0x11, that is 0x11, 0x22 and so on up to 0x88. Register i appears on cfg_o[8i+7:8i].
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When 1, pull the data line low |
| cfg_o | output | 64 | Register contents, register i at bits [8i+7:8i] |

## Verification
The bench aims at the boundaries of the pointer and of the transfer.

- **Block write longer than the bank.** A design that wraps the pointer would overwrite register 0.
- **Write to an out-of-range offset, or a second byte in byte mode.** A design that drops the range check would corrupt a neighbouring register.
- **Transfer cut off by a stop half-way through a byte.** A design that commits the byte at the stop would store a partial byte.
- **Wrong address.** A design that keeps decoding would acknowledge or write the bytes that follow.
- **Master NACK during a read.** A slave that keeps shifting would be seen as zero bits where only a released line should appear.
- **Block read.** This checks that the count byte comes first; a design that omits it would be off by one byte for every register.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } sm_state_t;

  localparam int PTR_W   = 7;
  localparam int BYTE_W  = 8;

endpackage

// File: rtl/smbus_cfg_sync.sv
module smbus_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  // Both lines idle high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs #(
  parameter int NREG = 8,
  parameter int AW   = 3,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] cfg
);

  logic [NREG*8-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= DEFAULTS;
    end else if (we) begin
      for (int i = 0; i < NREG; i++) begin
        if (waddr == AW'(i)) bank_q[i*8 +: 8] <= wdata;
      end
    end
  end

  assign rdata = bank_q[raddr*8 +: 8];
  assign cfg   = bank_q;

endmodule

// File: rtl/smbus_cfg_fsm.sv
module smbus_cfg_fsm
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 8,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] raddr,
  output logic          sda_oe
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NREG);
  localparam logic [PTR_W-1:0] PTR_OFF = '1;

  sm_state_t         st_q, st_n, after_q, after_n;
  logic [7:0]        sh_q, sh_n, cmd_q, cmd_n;
  logic [3:0]        bit_q, bit_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n, ptr_adv;
  logic              oe_q, oe_n, cntp_q, cntp_n, nack_q, nack_n;
  logic              in_range;
  logic [7:0]        tx_byte;

  assign in_range = (ptr_q < PTR_END);
  // Byte mode moves the pointer off the bank after one byte; block mode steps and saturates.
  assign ptr_adv  = cmd_q[7] ? PTR_OFF : (in_range ? ptr_q + 1'b1 : ptr_q);
  assign tx_byte  = cntp_q ? 8'(NREG) : (in_range ? rdata : 8'h00);
  assign raddr    = ptr_q[AW-1:0];
  assign waddr    = ptr_q[AW-1:0];
  assign wdata    = sh_q;
  assign sda_oe   = oe_q;

  always_comb begin
    st_n    = st_q;
    after_n = after_q;
    sh_n    = sh_q;
    cmd_n   = cmd_q;
    bit_n   = bit_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    cntp_n  = cntp_q;
    nack_n  = nack_q;
    we      = 1'b0;
    if (stop_ev) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_ev) begin
      st_n  = ST_ADDR;
      bit_n = '0;
      oe_n  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_n = '0;
            oe_n  = 1'b1;
            st_n  = ST_ACK;
            unique case (st_q)
              ST_ADDR: begin
                if (sh_q[7:1] != DEV_ADDR) begin
                  oe_n = 1'b0;
                  st_n = ST_WAIT;
                end else if (sh_q[0]) begin
                  after_n = ST_TX;
                  cntp_n  = ~cmd_q[7];
                  ptr_n   = cmd_q[7] ? cmd_q[6:0] : '0;
                end else begin
                  after_n = ST_CMD;
                end
              end
              ST_CMD: begin
                cmd_n   = sh_q;
                ptr_n   = sh_q[7] ? sh_q[6:0] : '0;
                after_n = sh_q[7] ? ST_WDAT : ST_CNT;
              end
              ST_CNT:  after_n = ST_WDAT;
              default: begin
                we      = in_range;
                ptr_n   = ptr_adv;
                after_n = ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK, ST_MACK: begin
          if (scl_rise) nack_n = sda_s;
          if (scl_fall) begin
            bit_n = '0;
            if (st_q == ST_MACK && nack_q) begin
              st_n = ST_WAIT;
            end else if (st_q == ST_MACK || after_q == ST_TX) begin
              st_n = ST_TX;
              sh_n = tx_byte;
              oe_n = ~tx_byte[7];
              if (cntp_q) cntp_n = 1'b0;
              else        ptr_n  = ptr_adv;
            end else begin
              st_n = after_q;
              oe_n = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_n  = 1'b0;
              bit_n = '0;
              st_n  = ST_MACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              oe_n  = ~sh_q[6];
              bit_n = bit_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      after_q <= ST_IDLE;
      sh_q    <= '0;
      cmd_q   <= '0;
      bit_q   <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      cntp_q  <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      st_q    <= st_n;
      after_q <= after_n;
      sh_q    <= sh_n;
      cmd_q   <= cmd_n;
      bit_q   <= bit_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      cntp_q  <= cntp_n;
      nack_q  <= nack_n;
    end
  end

  // R9
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT || st_q == ST_IDLE) |-> !oe_q);

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'd8);

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] DEFAULTS = 64'h8877_6655_4433_2211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_o
);

  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0] wdata, rdata;

  smbus_cfg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smbus_cfg_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .AW(AW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rdata(rdata), .we(we), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .sda_oe(sda_oe_o)
  );

  smbus_cfg_regs #(.NREG(NREG), .AW(AW), .DEFAULTS(DEFAULTS)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .cfg(cfg_o)
  );

  // R6
  cfg_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(scl_fall));

endmodule

// File: tb/smbus_cfg_slave_tb.sv
module smbus_cfg_slave_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] cfg;
  wire  sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smbus_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  typedef struct {
    string      tag;
    logic [7:0] val;
  } exp_item_t;

  exp_item_t  exp_q[$];
  logic [7:0] obs_val;
  event       obs_ev;
  int         checks = 0;
  int         errors = 0;
  int         viol   = 0;
  logic       oe_prev = 1'b0;
  logic       done = 1'b0;
  logic [7:0] model [8];

  // Scoreboard monitor: pops one expected item per observation.
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: actual=%02h expected=<none>", obs_val);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        checks++;
        if (it.val !== obs_val) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, obs_val, it.val);
        end
      end
    end
  end

  // R9: SDA drive must not move while SCL is high.
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [7:0] exp, input logic [7:0] act);
    exp_q.push_back('{tag, exp});
    obs_val = act;
    -> obs_ev;
    #1;
  endtask

  task automatic wait_t();
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; wait_t();
    scl_m = 1'b1; wait_t(); wait_t();
    scl_m = 1'b0; wait_t();
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wait_t();
    scl_m = 1'b1; wait_t();
    b = sda_bus; wait_t();
    scl_m = 1'b0; wait_t();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_t();
    scl_m = 1'b1; wait_t();
    sda_m = 1'b0; wait_t();
    scl_m = 1'b0; wait_t();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_t();
    scl_m = 1'b1; wait_t();
    sda_m = 1'b1; wait_t();
  endtask

  task automatic wr_byte(input logic [7:0] v, input string tag, input logic exp_ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(a);
    chk(tag, {7'b0, exp_ack}, {7'b0, a});
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_r(v[i]);
    bit_w(nack);
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 8; i++) chk(tag, model[i], cfg[i*8 +: 8]);
  endtask

  task automatic byte_read(input logic [6:0] off, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_start();
    wr_byte(8'hD2, tag, 1'b0);
    wr_byte({1'b1, off}, tag, 1'b0);
    bus_start();
    wr_byte(8'hD3, tag, 1'b0);
    rd_byte(v, 1'b1);
    chk(tag, exp, v);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) model[i] = 8'((i + 1) * 8'h11);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_t();

    // R8: defaults after reset
    chk_regs("R8");

    // R2: byte write to offset 3, extra byte discarded
    bus_start();
    wr_byte(8'hD2, "R1", 1'b0);
    wr_byte(8'h83, "R2", 1'b0);
    wr_byte(8'hA5, "R2", 1'b0);
    wr_byte(8'h5A, "R2", 1'b0);
    bus_stop();
    model[3] = 8'hA5;
    chk_regs("R2");

    // R2: out-of-range offset is acknowledged and dropped
    bus_start();
    wr_byte(8'hD2, "R2", 1'b0);
    wr_byte(8'h8A, "R2", 1'b0);
    wr_byte(8'hEE, "R2", 1'b0);
    bus_stop();
    chk_regs("R2");

    // R3: byte reads in and out of range
    byte_read(7'd3, 8'hA5, "R3");
    byte_read(7'd5, 8'h66, "R3");
    byte_read(7'd12, 8'h00, "R3");

    // R4: block write of three bytes
    bus_start();
    wr_byte(8'hD2, "R4", 1'b0);
    wr_byte(8'h00, "R4", 1'b0);
    wr_byte(8'h03, "R4", 1'b0);
    wr_byte(8'h10, "R4", 1'b0);
    wr_byte(8'h20, "R4", 1'b0);
    wr_byte(8'h30, "R4", 1'b0);
    bus_stop();
    model[0] = 8'h10; model[1] = 8'h20; model[2] = 8'h30;
    chk_regs("R4");

    // R4: block write past the end of the bank
    bus_start();
    wr_byte(8'hD2, "R4", 1'b0);
    wr_byte(8'h00, "R4", 1'b0);
    wr_byte(8'h0A, "R4", 1'b0);
    for (int i = 0; i < 10; i++) wr_byte(8'(8'h40 + i), "R4", 1'b0);
    bus_stop();
    for (int i = 0; i < 8; i++) model[i] = 8'(8'h40 + i);
    chk_regs("R4");

    // R1: foreign address gets no acknowledge and writes nothing
    bus_start();
    wr_byte(8'hA4, "R1", 1'b1);
    wr_byte(8'h00, "R1", 1'b1);
    wr_byte(8'h01, "R1", 1'b1);
    wr_byte(8'hFF, "R1", 1'b1);
    bus_stop();
    chk_regs("R1");

    // R6: stop in the middle of a byte keeps earlier bytes only
    bus_start();
    wr_byte(8'hD2, "R6", 1'b0);
    wr_byte(8'h00, "R6", 1'b0);
    wr_byte(8'h03, "R6", 1'b0);
    wr_byte(8'hC1, "R6", 1'b0);
    for (int i = 0; i < 4; i++) bit_w(1'b0);
    bus_stop();
    model[0] = 8'hC1;
    chk_regs("R6");

    // R5: block read returns count then the bank, then zeros
    bus_start();
    wr_byte(8'hD2, "R5", 1'b0);
    wr_byte(8'h00, "R5", 1'b0);
    bus_start();
    wr_byte(8'hD3, "R5", 1'b0);
    rd_byte(v, 1'b0);
    chk("R5", 8'h08, v);
    for (int i = 0; i < 8; i++) begin
      rd_byte(v, 1'b0);
      chk("R5", model[i], v);
    end
    rd_byte(v, 1'b1);
    chk("R5", 8'h00, v);
    bus_stop();

    // R7: after a master NACK the line stays released
    bus_start();
    wr_byte(8'hD2, "R7", 1'b0);
    wr_byte(8'h81, "R7", 1'b0);
    bus_start();
    wr_byte(8'hD3, "R7", 1'b0);
    rd_byte(v, 1'b1);
    chk("R7", model[1], v);
    rd_byte(v, 1'b1);
    chk("R7", 8'hFF, v);
    bus_stop();

    // R9: no drive change was seen with SCL high
    chk("R9", 8'h00, 8'(viol));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule